// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block turns a 4 KiB window of a simple host bus into accesses on an ATA task-file interface. Each host request carries an address, a size (byte, halfword or word), a direction and write data. The bridge takes a register index from the address and sends the request to one of four places. Byte accesses go to the seven task-file registers or to the device-control register, which also serves alternate-status reads. Halfword and word accesses go to the 16-bit data port. Any access that matches none of these is absorbed.

The host bus is big-endian and the device is little-endian. Data-port traffic is therefore byte-reversed in both directions, and all other traffic passes through unchanged. The data port is 16 bits wide, so a word access becomes two back-to-back halfword transfers. The bridge holds its ready signal low while the second transfer runs. Every access returns one registered response pulse after its last device transfer. Writes return zero read data.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is host address bits [11:4]. Address bits [3:0] and bits above bit 11 have no effect on routing.
- R2: A byte access (size 0) at index 1..7 reaches task-file register 1..7 on `tf_idx`. A write drives `tf_wr` with `req_wdata[7:0]`. A read pulses `tf_rd` and returns `tf_rdata` in `rsp_rdata[7:0]` with the upper bits zero.
- R3: A byte write at index 8 or 22 loads `req_wdata[7:0]` into `dev_ctl`. A byte read at index 8 or 22 returns `alt_status` and pulses no device strobe.
- R4: A byte read at any other index returns 0x000000FF. A byte write at any other index changes no task-file register and leaves `dev_ctl` unchanged.
- R5: A halfword access (size 1) at index 0 makes one data-port transfer. The write value is `req_wdata[15:0]` with its two bytes swapped, and the read value is `dp_rdata` with its bytes swapped, returned in `rsp_rdata[15:0]`.
- R6: A word access (size 2 or 3) at index 0 makes two data-port transfers in consecutive cycles. A write first reverses all four bytes of `req_wdata`, then sends bits [15:0] followed by bits [31:16]. A read places the first halfword in bits [15:0] and the second in bits [31:16], then reverses all four bytes.
- R7: A halfword or word access at a nonzero index makes no data-port transfer. A read returns 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R8: `req_ready` is high whenever no word transfer is in progress. `rsp_valid` pulses one cycle after a single-transfer access is accepted, and two cycles after a word data-port access is accepted. `req_ready` is low in the cycle between.
- R9: While `rst` is high, `dev_ctl` clears to 0x00, `rsp_valid` goes low and the bridge returns to idle with `req_ready` high.
- R10: In any cycle at most one of `tf_wr`, `tf_rd`, `dp_wr` and `dp_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Registered read data, right-aligned |
| tf_idx | output | 3 | Task-file register select |
| tf_wr | output | 1 | Task-file write strobe |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wdata | output | 8 | Task-file write byte |
| tf_rdata | input | 8 | Task-file read byte |
| dev_ctl | output | 8 | Device-control register |
| alt_status | input | 8 | Alternate-status value from the device |
| dp_wr | output | 1 | Data-port write strobe |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wdata | output | 16 | Data-port write halfword, device order |
| dp_rdata | input | 16 | Data-port read halfword, device order |

## Verification
Random requests mix all three sizes, both directions, and indices taken from the data port, the task file, both control aliases and the unmapped space. The upper address bits and the low nibble are random, which shows whether routing looks only at bits [11:4]. The data-port stub returns a halfword that changes with every read, so a swapped byte order, or halfwords taken in the wrong order, gives a value different from the expected one. Directed cases read the control aliases, index 0 with byte size, the top index, and multi-byte sizes at task-file indices. For each of these the bench tracks the strobe counts, and so separates an absorbed access from one that reached a register.

// File: rtl/mmio_ata_pkg.sv
package mmio_ata_pkg;
   localparam int HOST_W = 32;
   localparam int DP_W   = 16;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   typedef enum logic [1:0] {
      RT_TASK = 2'd0,
      RT_CTL  = 2'd1,
      RT_DATA = 2'd2,
      RT_NONE = 2'd3
   } route_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_HIGH = 1'b1
   } phase_t;
endpackage

// File: rtl/mmio_ata_swap.sv
module mmio_ata_swap #(
   parameter int LANES = 4
) (
   input  logic [LANES*8-1:0] din,
   output logic [LANES*8-1:0] dout
);
   generate
      if (LANES < 1) begin : g_bad
         $error("mmio_ata_swap: LANES must be at least 1");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign dout[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/mmio_ata_decode.sv
module mmio_ata_decode
   import mmio_ata_pkg::*;
#(
   parameter int HADDR_W    = 32,
   parameter int WIN_W      = 12,
   parameter int STRIDE_LSB = 4,
   parameter int CTL_IDX_A  = 8,
   parameter int CTL_IDX_B  = 22,
   parameter int TF_LAST    = 7
) (
   input  logic [HADDR_W-1:0] addr,
   input  logic [1:0]         size,
   output route_t             route,
   output logic [2:0]         tf_sel
);
   localparam int IDX_W = WIN_W - STRIDE_LSB;

   logic [IDX_W-1:0] idx;
   assign idx    = addr[WIN_W-1:STRIDE_LSB];
   assign tf_sel = idx[2:0];

   always_comb begin
      route = RT_NONE;
      if (size == SZ_BYTE) begin
         if (idx >= IDX_W'(1) && idx <= IDX_W'(TF_LAST))
            route = RT_TASK;
         else if (idx == IDX_W'(CTL_IDX_A) || idx == IDX_W'(CTL_IDX_B))
            route = RT_CTL;
      end else if (idx == '0) begin
         route = RT_DATA;
      end
   end
endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
   import mmio_ata_pkg::*;
#(
   parameter int HADDR_W    = 32,
   parameter int WIN_W      = 12,
   parameter int STRIDE_LSB = 4,
   parameter int CTL_IDX_A  = 8,
   parameter int CTL_IDX_B  = 22,
   parameter int TF_LAST    = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [HADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic [2:0]        tf_idx,
   output logic              tf_wr,
   output logic              tf_rd,
   output logic [7:0]        tf_wdata,
   input  logic [7:0]        tf_rdata,
   output logic [7:0]        dev_ctl,
   input  logic [7:0]        alt_status,
   output logic              dp_wr,
   output logic              dp_rd,
   output logic [15:0]       dp_wdata,
   input  logic [15:0]       dp_rdata
);
   localparam int IDX_W    = WIN_W - STRIDE_LSB;
   localparam int IDX_MAX  = (1 << IDX_W) - 1;
   localparam int H_LANES  = DP_W / 8;
   localparam int W_LANES  = HOST_W / 8;

   generate
      if (WIN_W <= STRIDE_LSB || WIN_W > HADDR_W) begin : g_bad_win
         $error("mmio_ata_bridge: window width inconsistent with stride");
      end
      if (CTL_IDX_A > IDX_MAX || CTL_IDX_B > IDX_MAX) begin : g_bad_ctl
         $error("mmio_ata_bridge: control index outside window");
      end
      if (TF_LAST < 1 || TF_LAST > 7) begin : g_bad_tf
         $error("mmio_ata_bridge: task-file range must be 1..7");
      end
   endgenerate

   route_t      route;
   logic [2:0]  tf_sel;
   phase_t      phase;
   logic        hi_write;
   logic [15:0] hi_buf;
   logic [15:0] lo_cap;
   logic        accept;
   logic        is_word;
   logic [15:0] wr_sw16;
   logic [31:0] wr_sw32;
   logic [15:0] rd_sw16;
   logic [31:0] rd_sw32;
   logic [31:0] rd_now;

   mmio_ata_decode #(
      .HADDR_W(HADDR_W), .WIN_W(WIN_W), .STRIDE_LSB(STRIDE_LSB),
      .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B), .TF_LAST(TF_LAST)
   ) u_dec (
      .addr(req_addr), .size(req_size), .route(route), .tf_sel(tf_sel)
   );

   mmio_ata_swap #(.LANES(H_LANES)) u_sw_wh (.din(req_wdata[15:0]), .dout(wr_sw16));
   mmio_ata_swap #(.LANES(W_LANES)) u_sw_ww (.din(req_wdata),       .dout(wr_sw32));
   mmio_ata_swap #(.LANES(H_LANES)) u_sw_rh (.din(dp_rdata),        .dout(rd_sw16));
   mmio_ata_swap #(.LANES(W_LANES)) u_sw_rw (.din({dp_rdata, lo_cap}), .dout(rd_sw32));

   assign req_ready = (phase == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign is_word   = (req_size != SZ_HALF);

   assign tf_idx   = tf_sel;
   assign tf_wdata = req_wdata[7:0];
   assign tf_wr    = accept &&  req_write && (route == RT_TASK);
   assign tf_rd    = accept && !req_write && (route == RT_TASK);

   assign dp_wr = (accept &&  req_write && (route == RT_DATA)) ||
                  ((phase == ST_HIGH) &&  hi_write);
   assign dp_rd = (accept && !req_write && (route == RT_DATA)) ||
                  ((phase == ST_HIGH) && !hi_write);
   assign dp_wdata = (phase == ST_HIGH) ? hi_buf :
                     (is_word ? wr_sw32[15:0] : wr_sw16);

   always_comb begin
      rd_now = '0;
      if (!req_write) begin
         unique case (route)
            RT_TASK: rd_now = {24'd0, tf_rdata};
            RT_CTL:  rd_now = {24'd0, alt_status};
            RT_DATA: rd_now = {16'd0, rd_sw16};
            RT_NONE: begin
               if (req_size == SZ_BYTE)      rd_now = 32'h0000_00FF;
               else if (req_size == SZ_HALF) rd_now = 32'h0000_FFFF;
               else                          rd_now = 32'hFFFF_FFFF;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase     <= ST_IDLE;
         hi_write  <= 1'b0;
         hi_buf    <= '0;
         lo_cap    <= '0;
         dev_ctl   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (phase == ST_HIGH) begin
            phase     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= hi_write ? 32'd0 : rd_sw32;
         end else if (accept) begin
            if (route == RT_CTL && req_write)
               dev_ctl <= req_wdata[7:0];
            if (route == RT_DATA && is_word) begin
               phase    <= ST_HIGH;
               hi_write <= req_write;
               hi_buf   <= wr_sw32[31:16];
               lo_cap   <= dp_rdata;
            end else begin
               rsp_valid <= 1'b1;
               rsp_rdata <= rd_now;
            end
         end
      end
   end
endmodule

// File: rtl/mmio_ata_bridge_chk.sv
module mmio_ata_bridge_chk #(
   parameter int HADDR_W    = 32,
   parameter int WIN_W      = 12,
   parameter int STRIDE_LSB = 4,
   parameter int CTL_IDX_A  = 8,
   parameter int CTL_IDX_B  = 22,
   parameter int TF_LAST    = 7
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [HADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              tf_wr,
   input logic              tf_rd,
   input logic [7:0]        dev_ctl,
   input logic              dp_wr,
   input logic              dp_rd
);
   localparam int IDX_W = WIN_W - STRIDE_LSB;

   logic [IDX_W-1:0] c_idx;
   logic c_acc, c_word_dp, c_ctl_wr, c_byte_unmapped;
   assign c_idx     = req_addr[WIN_W-1:STRIDE_LSB];
   assign c_acc     = req_valid && req_ready;
   assign c_word_dp = c_acc && req_size[1] && (c_idx == '0);
   assign c_ctl_wr  = c_acc && req_write && (req_size == 2'd0) &&
                      (c_idx == IDX_W'(CTL_IDX_A) || c_idx == IDX_W'(CTL_IDX_B));
   assign c_byte_unmapped = c_acc && (req_size == 2'd0) &&
                      (c_idx > IDX_W'(TF_LAST)) &&
                      (c_idx != IDX_W'(CTL_IDX_A)) && (c_idx != IDX_W'(CTL_IDX_B));

   a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $countones({tf_wr, tf_rd, dp_wr, dp_rd}) <= 1);

   a_r8_word_stall: assert property (@(posedge clk) disable iff (rst)
      c_word_dp |=> (!req_ready && (dp_wr || dp_rd) && !rsp_valid));

   a_r8_single_resp: assert property (@(posedge clk) disable iff (rst)
      (c_acc && !c_word_dp) |=> (rsp_valid && req_ready));

   a_r3_ctl_hold: assert property (@(posedge clk) disable iff (rst)
      !c_ctl_wr |=> $stable(dev_ctl));

   a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
      c_byte_unmapped |-> (!tf_wr && !tf_rd && !dp_wr && !dp_rd));

   a_r9_reset_idle: assert property (@(posedge clk)
      rst |=> (dev_ctl == 8'd0 && !rsp_valid && req_ready));
endmodule

bind mmio_ata_bridge mmio_ata_bridge_chk #(
   .HADDR_W(HADDR_W), .WIN_W(WIN_W), .STRIDE_LSB(STRIDE_LSB),
   .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B), .TF_LAST(TF_LAST)
) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .tf_wr(tf_wr), .tf_rd(tf_rd), .dev_ctl(dev_ctl),
   .dp_wr(dp_wr), .dp_rd(dp_rd)
);

// File: tb/mmio_ata_bridge_test.sv
module mmio_ata_bridge_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [2:0]  tf_idx;
   logic        tf_wr, tf_rd, dp_wr, dp_rd;
   logic [7:0]  tf_wdata, tf_rdata, dev_ctl;
   logic [7:0]  alt_status = 8'h50;
   logic [15:0] dp_wdata, dp_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   mmio_ata_bridge uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .tf_idx(tf_idx), .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_wdata(tf_wdata),
      .tf_rdata(tf_rdata), .dev_ctl(dev_ctl), .alt_status(alt_status),
      .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
   );

   // device stub
   logic [7:0]  tf_mem [0:7];
   logic [15:0] dp_log [0:3];
   int dp_rd_cnt = 0, dp_wr_cnt = 0, tf_rd_cnt = 0;

   function automatic logic [15:0] pat(input int c);
      logic [7:0] b = c[7:0];
      return {b ^ 8'hC3, b + 8'h11};
   endfunction
   function automatic logic [15:0] sw16(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction
   function automatic logic [31:0] sw32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   assign tf_rdata = tf_mem[tf_idx];
   assign dp_rdata = pat(dp_rd_cnt);

   initial for (int i = 0; i < 8; i++) tf_mem[i] = 8'(i * 17);

   always @(posedge clk) begin
      if (tf_wr) tf_mem[tf_idx] <= tf_wdata;
      if (tf_rd) tf_rd_cnt <= tf_rd_cnt + 1;
      if (dp_rd) dp_rd_cnt <= dp_rd_cnt + 1;
      if (dp_wr) begin
         dp_log[dp_wr_cnt % 4] <= dp_wdata;
         dp_wr_cnt <= dp_wr_cnt + 1;
      end
   end

   // bench model
   logic [7:0] tf_model [0:7];
   logic [7:0] ctl_model = 8'h00;
   initial for (int i = 0; i < 8; i++) tf_model[i] = 8'(i * 17);

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 10) begin
         @(negedge clk);
         cyc++;
      end
      rd = rsp_rdata;
   endtask

   function automatic bit tf_same();
      for (int i = 1; i < 8; i++) if (tf_mem[i] !== tf_model[i]) return 0;
      return 1;
   endfunction

   task automatic run_one(input logic wr, input logic [1:0] sz, input logic [7:0] idx);
      logic [31:0] a, wd, rd, ex;
      int cyc, c0r, c0w, t0;
      bit word_dp, tfi, ctli;
      a  = {$urandom() % 32'h100000, idx, 4'($urandom())};   // R1 random upper/lower bits
      wd = $urandom();
      c0r = dp_rd_cnt; c0w = dp_wr_cnt; t0 = tf_rd_cnt;
      word_dp = (sz != 2'd0 && sz != 2'd1 && idx == 8'd0);
      tfi  = (sz == 2'd0 && idx >= 8'd1 && idx <= 8'd7);
      ctli = (sz == 2'd0 && (idx == 8'd8 || idx == 8'd22));
      access(wr, sz, a, wd, rd, cyc);
      check(cyc == (word_dp ? 2 : 1), "R8 response latency", 32'(cyc), word_dp ? 2 : 1);
      if (!wr) begin
         if (tfi)       ex = {24'd0, tf_model[idx[2:0]]};
         else if (ctli) ex = {24'd0, alt_status};
         else if (sz == 2'd0) ex = 32'hFF;
         else if (idx != 8'd0) ex = (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
         else if (sz == 2'd1) ex = {16'd0, sw16(pat(c0r))};
         else ex = sw32({pat(c0r + 1), pat(c0r)});
         check(rd === ex, tfi ? "R2 tf read" : ctli ? "R3 alt read" :
               sz == 2'd0 ? "R4 unmapped byte read" : idx != 8'd0 ? "R7 multi read unmapped" :
               sz == 2'd1 ? "R5 half read" : "R6 word read", rd, ex);
         check(tf_rd_cnt == t0 + (tfi ? 1 : 0), "R3 read strobe count", 32'(tf_rd_cnt),
               32'(t0 + (tfi ? 1 : 0)));
      end else begin
         if (tfi) tf_model[idx[2:0]] = wd[7:0];
         if (ctli) ctl_model = wd[7:0];
         check(tf_same(), tfi ? "R2 tf write" : "R4 tf untouched", 32'(idx), 32'(idx));
         check(dev_ctl === ctl_model, ctli ? "R3 ctl write" : "R4 ctl unchanged",
               32'(dev_ctl), 32'(ctl_model));
         if (sz != 2'd0 && idx == 8'd0) begin
            if (sz == 2'd1) begin
               check(dp_wr_cnt == c0w + 1, "R5 one transfer", 32'(dp_wr_cnt), 32'(c0w + 1));
               check(dp_log[c0w % 4] === sw16(wd[15:0]), "R5 half write",
                     32'(dp_log[c0w % 4]), 32'(sw16(wd[15:0])));
            end else begin
               ex = sw32(wd);
               check(dp_wr_cnt == c0w + 2, "R6 two transfers", 32'(dp_wr_cnt), 32'(c0w + 2));
               check({dp_log[(c0w + 1) % 4], dp_log[c0w % 4]} === ex, "R6 word write order",
                     {dp_log[(c0w + 1) % 4], dp_log[c0w % 4]}, ex);
            end
         end else begin
            check(dp_wr_cnt == c0w, "R7 no data write", 32'(dp_wr_cnt), 32'(c0w));
         end
      end
      if (!(sz != 2'd0 && idx == 8'd0))
         check(dp_rd_cnt == c0r, "R7 no data read", 32'(dp_rd_cnt), 32'(c0r));
   endtask

   initial begin
      logic [7:0] idx;
      logic [1:0] sz;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      check(dev_ctl === 8'h00, "R9 ctl reset", 32'(dev_ctl), 0);
      check(rsp_valid === 1'b0, "R9 no response", 32'(rsp_valid), 0);
      check(req_ready === 1'b1, "R9 idle ready", 32'(req_ready), 1);
      rst = 1'b0;
      // directed corners
      run_one(1'b1, 2'd0, 8'd8);
      run_one(1'b0, 2'd0, 8'd22);
      run_one(1'b1, 2'd0, 8'd22);
      run_one(1'b0, 2'd0, 8'd8);
      run_one(1'b0, 2'd0, 8'd0);
      run_one(1'b1, 2'd0, 8'd255);
      run_one(1'b0, 2'd2, 8'd1);
      run_one(1'b0, 2'd1, 8'd8);
      run_one(1'b1, 2'd3, 8'd7);
      run_one(1'b1, 2'd2, 8'd0);
      run_one(1'b0, 2'd3, 8'd0);
      run_one(1'b1, 2'd1, 8'd0);
      run_one(1'b0, 2'd1, 8'd0);
      run_one(1'b1, 2'd0, 8'd7);
      run_one(1'b0, 2'd0, 8'd7);
      // random mix
      for (int n = 0; n < 400; n++) begin
         alt_status = 8'($urandom());
         case ($urandom() % 6)
            0: idx = 8'd0;
            1, 2: idx = 8'(1 + $urandom() % 7);
            3: idx = 8'd8;
            4: idx = 8'd22;
            default: begin
               idx = 8'(9 + $urandom() % 247);
               if (idx == 8'd22) idx = 8'd23;
            end
         endcase
         sz = 2'($urandom() % 4);
         run_one(1'($urandom()), sz, idx);
      end
      // R9: reset mid-run clears control
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check(dev_ctl === 8'h00, "R9 ctl cleared again", 32'(dev_ctl), 0);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule